// File: doc/BRIEF.md
# Linked-List Multi-Queue Node Pool

A single shared pool of list nodes lets any number of independent FIFO queues live in one memory. Each node holds a data word, a pointer to its successor, an occupied flag and an end-of-list flag, with every field held in its own array. The caller keeps the head and tail address of each of its queues. The block allocates nodes, links them and frees them.

An insert handshake either opens a new queue or links a node after a given tail. The address where the node was placed is offered on `ins_addr_o` in the same cycle as the handshake, so the caller can record it as the new tail, and as the head too when the queue is new. A pop names a head address. One cycle later the block returns that node's data, its end flag and its successor, and the node is already back in the free pool. When every node is occupied, insert is held not-ready.

Top module: `ll_node_pool`

## Requirements
- R1: After reset (`rst_ni` low, asynchronous) every node is free, `ins_ready_o` is 1, `ins_addr_o` is 0 and `pop_rvalid_o` is 0.
- R2: While `ins_ready_o` is 1, `ins_addr_o` is the lowest-numbered free node. An insert is accepted in any cycle with `ins_valid_i` and `ins_ready_o` both high, and the node is placed at that address.
- R3: `ins_ready_o` is 0 exactly when all nodes are occupied. An insert presented while it is 0 changes no node.
- R4: With `ins_append_i` = 0 the node starts a new queue: it stores `ins_data_i`, its end flag is 1 and its successor reads 0. `ins_addr_i` is ignored and the node it names is left unchanged.
- R5: With `ins_append_i` = 1 the node is placed as in R4, and the node at `ins_addr_i` gets its end flag cleared and its successor set to the new address.
- R6: A pop (`pop_valid_i` = 1 with `pop_addr_i`) raises `pop_rvalid_o` on the next cycle, with `pop_data_o`, `pop_last_o` and `pop_next_o` carrying the addressed node's data, end flag and successor. In a cycle with no pop, `pop_rvalid_o` is 0 on the next cycle.
- R7: Every popped node is freed at the same clock edge, and the allocator can choose it from the next cycle on.
- R8: Following the successor pointers from a head returns the nodes in the order they were inserted, even when several queues are interleaved in the pool.
- R9: An insert and a pop in the same cycle both take effect. The allocation is decided from the occupancy before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_append_i | input | 1 | 1: link after `ins_addr_i`; 0: start a new queue |
| ins_addr_i | input | ADDR_W | Tail address used when appending |
| ins_data_i | input | DATA_W | Data to store |
| ins_ready_o | output | 1 | A free node exists |
| ins_addr_o | output | ADDR_W | Address the node is or will be placed at |
| pop_valid_i | input | 1 | Pop request |
| pop_addr_i | input | ADDR_W | Head address to pop |
| pop_rvalid_o | output | 1 | Pop response valid |
| pop_data_o | output | DATA_W | Popped node's data |
| pop_last_o | output | 1 | Popped node was the end of its queue |
| pop_next_o | output | ADDR_W | Popped node's successor |

## Verification
The bench builds the pool with its defaults: four nodes of 8-bit data. With so few nodes it can fill the whole pool, see the not-ready state, and bring each allocation choice from lowest-free through full and back. Two queues are interleaved so that the successor pointers cross node indices and wrap back to node 0. The reused node 0 then shows that a node freed by a pop is handed out again.

// File: rtl/ll_pool_pkg.sv
package ll_pool_pkg;
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ll_alloc.sv
module ll_alloc #(
  parameter int NODES  = 4,
  parameter int ADDR_W = 2
) (
  input  logic [NODES-1:0]  vld_i,
  output logic              found_o,
  output logic [ADDR_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        found_o = 1'b1;
        idx_o   = ADDR_W'(i);
      end
    end
  end

  // R2: chosen slot is free and every lower slot is taken
  logic [NODES-1:0] below;
  always_comb
    for (int i = 0; i < NODES; i++) below[i] = (ADDR_W'(i) < idx_o);

  always_comb begin
    if (found_o) begin
      a_r2_slot_free : assert (!vld_i[idx_o]);
      a_r2_lowest    : assert ((vld_i & below) == below);
    end else begin
      a_r3_full      : assert (&vld_i);
    end
  end
endmodule

// File: rtl/ll_node_store.sv
module ll_node_store #(
  parameter int NODES  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_we_i,
  input  logic              ins_append_i,
  input  logic [ADDR_W-1:0] ins_tail_i,
  input  logic [ADDR_W-1:0] ins_slot_i,
  input  logic [DATA_W-1:0] ins_data_i,
  input  logic              pop_en_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  output logic [NODES-1:0]  vld_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic [ADDR_W-1:0] rd_next_o
);
  logic [DATA_W-1:0] data_q [NODES];
  logic [ADDR_W-1:0] next_q [NODES];
  logic [NODES-1:0]  vld_q;
  logic [NODES-1:0]  last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      last_q <= '0;
      for (int i = 0; i < NODES; i++) begin
        data_q[i] <= '0;
        next_q[i] <= '0;
      end
    end else begin
      if (pop_en_i) vld_q[pop_addr_i] <= 1'b0;
      if (ins_we_i) begin
        vld_q[ins_slot_i]  <= 1'b1;
        last_q[ins_slot_i] <= 1'b1;
        data_q[ins_slot_i] <= ins_data_i;
        next_q[ins_slot_i] <= '0;
        if (ins_append_i) begin
          last_q[ins_tail_i] <= 1'b0;
          next_q[ins_tail_i] <= ins_slot_i;
        end
      end
    end
  end

  assign vld_o     = vld_q;
  assign rd_data_o = data_q[pop_addr_i];
  assign rd_last_o = last_q[pop_addr_i];
  assign rd_next_o = next_q[pop_addr_i];

  a_r7_pop_frees : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_en_i && !(ins_we_i && ins_slot_i == pop_addr_i)) |=> !vld_q[$past(pop_addr_i)]);
  a_r4_new_tail : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_we_i |=> (vld_q[$past(ins_slot_i)] && last_q[$past(ins_slot_i)]));
  a_r5_link : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_we_i && ins_append_i) |=>
      (!last_q[$past(ins_tail_i)] && next_q[$past(ins_tail_i)] == $past(ins_slot_i)));
  a_r3_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_we_i && !pop_en_i) |=> $stable(vld_q));
endmodule

// File: rtl/ll_node_pool.sv
module ll_node_pool #(
  parameter int NODES  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = ll_pool_pkg::addr_bits(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic              ins_append_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [DATA_W-1:0] ins_data_i,
  output logic              ins_ready_o,
  output logic [ADDR_W-1:0] ins_addr_o,
  input  logic              pop_valid_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  output logic              pop_rvalid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_last_o,
  output logic [ADDR_W-1:0] pop_next_o
);
  logic [NODES-1:0]  vld;
  logic              free_found;
  logic [ADDR_W-1:0] free_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_last;
  logic [ADDR_W-1:0] rd_next;
  logic              ins_fire;

  ll_alloc #(.NODES(NODES), .ADDR_W(ADDR_W)) u_alloc (
    .vld_i   (vld),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  assign ins_ready_o = free_found;
  assign ins_addr_o  = free_idx;
  assign ins_fire    = ins_valid_i && free_found;

  ll_node_store #(.NODES(NODES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ins_we_i     (ins_fire),
    .ins_append_i (ins_append_i),
    .ins_tail_i   (ins_addr_i),
    .ins_slot_i   (free_idx),
    .ins_data_i   (ins_data_i),
    .pop_en_i     (pop_valid_i),
    .pop_addr_i   (pop_addr_i),
    .vld_o        (vld),
    .rd_data_o    (rd_data),
    .rd_last_o    (rd_last),
    .rd_next_o    (rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_rvalid_o <= 1'b0;
      pop_data_o   <= '0;
      pop_last_o   <= 1'b0;
      pop_next_o   <= '0;
    end else begin
      pop_rvalid_o <= pop_valid_i;
      if (pop_valid_i) begin
        pop_data_o <= rd_data;
        pop_last_o <= rd_last;
        pop_next_o <= rd_next;
      end
    end
  end

  a_r6_resp : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_i |=> pop_rvalid_o);
  a_r6_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_valid_i |=> !pop_rvalid_o);
  a_r9_alloc_moves : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_fire && !pop_valid_i) |=> (!ins_ready_o || ins_addr_o != $past(ins_addr_o)));
endmodule

// File: tb/sim_ll_node_pool.sv
module sim_ll_node_pool;
  localparam int NODES = 4, DATA_W = 8, AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_append = 0, ins_ready;
  logic [AW-1:0] ins_addr = '0, ins_addr_o;
  logic [DATA_W-1:0] ins_data = '0;
  logic pop_valid = 0, pop_rvalid, pop_last;
  logic [AW-1:0] pop_addr = '0, pop_next;
  logic [DATA_W-1:0] pop_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ll_node_pool #(.NODES(NODES), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_append_i(ins_append), .ins_addr_i(ins_addr),
    .ins_data_i(ins_data), .ins_ready_o(ins_ready), .ins_addr_o(ins_addr_o),
    .pop_valid_i(pop_valid), .pop_addr_i(pop_addr), .pop_rvalid_o(pop_rvalid),
    .pop_data_o(pop_data), .pop_last_o(pop_last), .pop_next_o(pop_next)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // op: 0 new queue, 1 append, 2 pop
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [7:0]  data;
    logic [1:0]  e_addr;
    logic [7:0]  e_data;
    logic        e_last;
    logic [1:0]  e_next;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd3, 8'hA1, 2'd0, 8'h00, 1'b0, 2'd0},
    '{2'd1, 2'd0, 8'hA2, 2'd1, 8'h00, 1'b0, 2'd0},
    '{2'd0, 2'd1, 8'hB1, 2'd2, 8'h00, 1'b0, 2'd0},
    '{2'd1, 2'd1, 8'hA3, 2'd3, 8'h00, 1'b0, 2'd0},
    '{2'd2, 2'd0, 8'h00, 2'd0, 8'hA1, 1'b0, 2'd1},
    '{2'd1, 2'd2, 8'hB2, 2'd0, 8'h00, 1'b0, 2'd0},
    '{2'd2, 2'd1, 8'h00, 2'd0, 8'hA2, 1'b0, 2'd3},
    '{2'd2, 2'd3, 8'h00, 2'd0, 8'hA3, 1'b1, 2'd0},
    '{2'd2, 2'd2, 8'h00, 2'd0, 8'hB1, 1'b0, 2'd0},
    '{2'd2, 2'd0, 8'h00, 2'd0, 8'hB2, 1'b1, 2'd0},
    '{2'd0, 2'd2, 8'hC1, 2'd0, 8'h00, 1'b0, 2'd0}
  };

  task automatic do_ins(input bit app, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [AW-1:0] e_addr, input string tag);
    @(negedge clk);
    ins_valid = 1; ins_append = app; ins_addr = a; ins_data = d;
    #1;
    chk(ins_ready === 1'b1, {tag, " ready"}, ins_ready, 1);
    chk(ins_addr_o === e_addr, {tag, " addr"}, ins_addr_o, e_addr);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0; ins_append = 0;
  endtask

  task automatic do_pop(input logic [AW-1:0] a, input logic [7:0] ed, input bit el,
                        input logic [AW-1:0] en, input string tag);
    @(negedge clk);
    pop_valid = 1; pop_addr = a;
    @(posedge clk);
    @(negedge clk);
    pop_valid = 0;
    chk(pop_rvalid === 1'b1, {tag, " rvalid"}, pop_rvalid, 1);
    chk(pop_data === ed, {tag, " data"}, pop_data, ed);
    chk(pop_last === el, {tag, " last"}, pop_last, el);
    chk(pop_next === en, {tag, " next"}, pop_next, en);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #7;
    // R1 reset state
    chk(ins_ready === 1'b1, "R1 ready", ins_ready, 1);
    chk(ins_addr_o === 2'd0, "R1 addr", ins_addr_o, 0);
    chk(pop_rvalid === 1'b0, "R1 rvalid", pop_rvalid, 0);
    @(negedge clk); rst_n = 1;

    // table: R4 new queues, R5 appends, R8 ordered pops across two queues
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: do_ins(0, TBL[i].addr, TBL[i].data, TBL[i].e_addr, "R4 new");
        2'd1: do_ins(1, TBL[i].addr, TBL[i].data, TBL[i].e_addr, "R5 append");
        default: do_pop(TBL[i].addr, TBL[i].e_data, TBL[i].e_last, TBL[i].e_next, "R8 pop");
      endcase
    end

    // R6: no pop -> rvalid low
    @(negedge clk);
    chk(pop_rvalid === 1'b0, "R6 idle", pop_rvalid, 0);

    // R2: fill remaining nodes lowest first
    do_ins(0, 2'd0, 8'hE1, 2'd1, "R2 fill");
    do_ins(0, 2'd0, 8'hE2, 2'd2, "R2 fill");
    do_ins(0, 2'd0, 8'hE3, 2'd3, "R2 fill");

    // R3: full -> not ready; insert attempt must not touch node 0
    @(negedge clk);
    ins_valid = 1; ins_append = 1; ins_addr = 2'd0; ins_data = 8'hFF;
    #1;
    chk(ins_ready === 1'b0, "R3 full", ins_ready, 0);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0; ins_append = 0;
    do_pop(2'd0, 8'hC1, 1'b1, 2'd0, "R3 untouched");

    // R7: freed node 0 offered again
    #1;
    chk(ins_ready === 1'b1, "R7 ready", ins_ready, 1);
    chk(ins_addr_o === 2'd0, "R7 reuse", ins_addr_o, 0);

    // R9: insert and pop together
    @(negedge clk);
    ins_valid = 1; ins_append = 0; ins_data = 8'hD1;
    pop_valid = 1; pop_addr = 2'd2;
    #1;
    chk(ins_addr_o === 2'd0, "R9 alloc", ins_addr_o, 0);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0; pop_valid = 0;
    chk(pop_rvalid === 1'b1, "R9 rvalid", pop_rvalid, 1);
    chk(pop_data === 8'hE2, "R9 data", pop_data, 8'hE2);
    #1;
    chk(ins_addr_o === 2'd2, "R9 freed", ins_addr_o, 2);
    do_pop(2'd0, 8'hD1, 1'b1, 2'd0, "R9 stored");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule